// File: doc/BRIEF.md
# Supply Reset Sequencer

This block turns two supply-monitor flags into the chip's system reset. One flag says the supply is above the power-on level, the other says it is above the brown-out level. Both arrive as asynchronous levels and are brought into the clock domain through a two-flop synchronizer. While either flag is low, the system reset stays active. When the supply comes up, release happens in stages. First a short power-on extension runs. Then a brown-out extension runs, followed at once by a power-up delay picked from eight settings. Every return of the brown-out flag starts that second stage again from zero.

Two sticky cause bits record whether the last reset came from a power loss or from a brown-out. Software reads these bits and overwrites them through a simple write strobe. A one-cycle pulse marks the cycle in which the system reset deasserts. All times are counted in clock cycles and are derived from a clock-frequency parameter. The `arst_n` input is the block's own asynchronous reset. It forces the system reset active at once, and release is always synchronous.

Top module: `supply_reset_seq`

## Requirements
- R1: While `arst_n` is low, `sys_rst_n_o` and `rst_released_o` are 0, `stat_por_o` is 1 and `stat_bor_o` is 0.
- R2: The system reset stays active while the synchronized power flag is low. From power-up, the release follows a fixed sequence. If both flags are driven high between the clock edges that follow cycle n, and both stay high, `sys_rst_n_o` rises at edge n+3+P+D. Here P = ceil((CLK_HZ/1000)·30/1000) cycles, with a minimum of 1.
- R3: When the brown-out flag drops while the system runs, `sys_rst_n_o` is still 1 after the second clock edge and is 0 after the third. The output stays 0 for as long as the flag remains low.
- R4: With the power flag high, a rise of the brown-out flag between the edges that follow cycle n releases reset at edge n+3+D. Here D = B + W, B = ceil((CLK_HZ/1000)·100/1000) cycles (minimum 1), and W is the power-up delay.
- R5: `pwrt_sel_i` code k gives W = 0 for k = 0 and W = (CLK_HZ/1000)·2^k cycles for k = 1 to 7. This corresponds to 0, 2, 4, 8, 16, 32, 64 and 128 ms.
- R6: If the brown-out flag drops during the B+W wait, the wait restarts from zero. Release comes at n+3+D, where n is the cycle after which the flag returned high.
- R7: A power-flag drop while running sets `stat_por_o`. If the brown-out flag falls at the same time, the event counts as a power loss only and `stat_bor_o` is unchanged.
- R8: A brown-out-flag drop while running, with the power flag still high, sets `stat_bor_o`.
- R9: A cycle with `stat_we_i` = 1 loads `stat_wdata_i[0]` into `stat_por_o` and `stat_wdata_i[1]` into `stat_bor_o`. The update is visible after that edge. A cause event in the same cycle wins over the written value for its own bit.
- R10: `rst_released_o` is high for exactly one cycle, namely the cycle in which `sys_rst_n_o` first becomes 1, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low block reset |
| por_ok_i | input | 1 | Supply above power-on level (asynchronous) |
| bor_ok_i | input | 1 | Supply above brown-out level (asynchronous) |
| pwrt_sel_i | input | 3 | Power-up delay code |
| stat_we_i | input | 1 | Cause-bit write strobe |
| stat_wdata_i | input | 2 | Cause-bit write data: bit0 power, bit1 brown-out |
| sys_rst_n_o | output | 1 | System reset, active low |
| rst_released_o | output | 1 | One-cycle pulse on reset release |
| stat_por_o | output | 1 | Sticky power-loss cause |
| stat_bor_o | output | 1 | Sticky brown-out cause |

## Verification
Two functions can fall in the same cycle: software writing a cause bit, and a supply event setting that same bit. The bench provokes this by dropping a supply flag and then timing a clearing write so that it is sampled on the exact edge where the synchronized drop is first seen in the running state. It does this once for the brown-out bit and once for the power bit. The result is judged by reading both bits one cycle later. The bit hit by the event must read 1, and the other bit must carry the written 0.

// File: rtl/supply_reset_pkg.sv
package supply_reset_pkg;
  typedef enum logic [2:0] {
    ST_POR_WAIT,
    ST_POR_EXT,
    ST_BOR_WAIT,
    ST_BOR_EXT,
    ST_RUN
  } seq_state_e;
endpackage

// File: rtl/sup_sync_bits.sv
module sup_sync_bits #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain_q[s] <= '0;
      else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sup_delay_timer.sv
module sup_delay_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign done_o = en_i && (cnt_q == (target_i - CNT_W'(1)));
endmodule

// File: rtl/sup_cause_regs.sv
module sup_cause_regs (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       por_evt_i,
  input  logic       bor_evt_i,
  input  logic       we_i,
  input  logic [1:0] wdata_i,
  output logic       por_o,
  output logic       bor_o
);
  logic por_q, por_d, bor_q, bor_d;

  always_comb begin
    por_d = por_q;
    bor_d = bor_q;
    if (we_i) begin
      por_d = wdata_i[0];
      bor_d = wdata_i[1];
    end
    if (por_evt_i) por_d = 1'b1;
    if (bor_evt_i) bor_d = 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      por_q <= 1'b1;
      bor_q <= 1'b0;
    end else begin
      por_q <= por_d;
      bor_q <= bor_d;
    end
  end

  assign por_o = por_q;
  assign bor_o = bor_q;
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
  import supply_reset_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned POR_US = 30,
  parameter int unsigned BOR_US = 100
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       por_ok_i,
  input  logic       bor_ok_i,
  input  logic [2:0] pwrt_sel_i,
  input  logic       stat_we_i,
  input  logic [1:0] stat_wdata_i,
  output logic       sys_rst_n_o,
  output logic       rst_released_o,
  output logic       stat_por_o,
  output logic       stat_bor_o
);
  localparam int unsigned MS_CYC  = CLK_HZ / 1000;
  localparam int unsigned POR_RAW = (MS_CYC * POR_US + 999) / 1000;
  localparam int unsigned BOR_RAW = (MS_CYC * BOR_US + 999) / 1000;
  localparam int unsigned POR_CYC = (POR_RAW == 0) ? 1 : POR_RAW;
  localparam int unsigned BOR_CYC = (BOR_RAW == 0) ? 1 : BOR_RAW;
  localparam int unsigned MAX_DLY = BOR_CYC + MS_CYC * 128 + POR_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_DLY + 1);

  logic       por_ok_s, bor_ok_s;
  logic [1:0] sync_q;

  sup_sync_bits #(.W(2), .STAGES(2)) i_sync (
    .clk   (clk),
    .arst_n(arst_n),
    .d_i   ({bor_ok_i, por_ok_i}),
    .q_o   (sync_q)
  );
  assign por_ok_s = sync_q[0];
  assign bor_ok_s = sync_q[1];

  seq_state_e       state_q, state_d;
  logic             tmr_clr, tmr_en, tmr_done;
  logic             por_evt, bor_evt;
  logic [CNT_W-1:0] pwrt_cyc, bor_tgt, tgt;

  always_comb begin
    if (pwrt_sel_i == 3'd0) pwrt_cyc = '0;
    else                    pwrt_cyc = CNT_W'(MS_CYC) << pwrt_sel_i;
    bor_tgt = CNT_W'(BOR_CYC) + pwrt_cyc;
  end

  always_comb begin
    state_d = state_q;
    tmr_en  = 1'b0;
    tgt     = bor_tgt;
    por_evt = 1'b0;
    bor_evt = 1'b0;
    unique case (state_q)
      ST_POR_WAIT: if (por_ok_s) state_d = ST_POR_EXT;
      ST_POR_EXT: begin
        tmr_en = 1'b1;
        tgt    = CNT_W'(POR_CYC);
        if (!por_ok_s)     state_d = ST_POR_WAIT;
        else if (tmr_done) state_d = bor_ok_s ? ST_BOR_EXT : ST_BOR_WAIT;
      end
      ST_BOR_WAIT: begin
        if (!por_ok_s)     state_d = ST_POR_WAIT;
        else if (bor_ok_s) state_d = ST_BOR_EXT;
      end
      ST_BOR_EXT: begin
        tmr_en = 1'b1;
        if (!por_ok_s)      state_d = ST_POR_WAIT;
        else if (!bor_ok_s) state_d = ST_BOR_WAIT;
        else if (tmr_done)  state_d = ST_RUN;
      end
      ST_RUN: begin
        if (!por_ok_s) begin
          state_d = ST_POR_WAIT;
          por_evt = 1'b1;
        end else if (!bor_ok_s) begin
          state_d = ST_BOR_WAIT;
          bor_evt = 1'b1;
        end
      end
      default: state_d = ST_POR_WAIT;
    endcase
    tmr_clr = (state_d != state_q);
  end

  sup_delay_timer #(.CNT_W(CNT_W)) i_timer (
    .clk     (clk),
    .arst_n  (arst_n),
    .clr_i   (tmr_clr),
    .en_i    (tmr_en),
    .target_i(tgt),
    .done_o  (tmr_done)
  );

  sup_cause_regs i_cause (
    .clk      (clk),
    .arst_n   (arst_n),
    .por_evt_i(por_evt),
    .bor_evt_i(bor_evt),
    .we_i     (stat_we_i),
    .wdata_i  (stat_wdata_i),
    .por_o    (stat_por_o),
    .bor_o    (stat_bor_o)
  );

  logic rst_n_q, rel_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_POR_WAIT;
      rst_n_q <= 1'b0;
      rel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rst_n_q <= (state_d == ST_RUN);
      rel_q   <= (state_d == ST_RUN) && (state_q != ST_RUN);
    end
  end

  assign sys_rst_n_o    = rst_n_q;
  assign rst_released_o = rel_q;
endmodule

// File: rtl/supply_reset_seq_chk.sv
module supply_reset_seq_chk (
  input logic clk,
  input logic arst_n,
  input logic por_ok_s,
  input logic bor_ok_s,
  input logic stat_we_i,
  input logic sys_rst_n_o,
  input logic rst_released_o,
  input logic stat_por_o,
  input logic stat_bor_o
);
  assert_por_low_holds_R2: assert property (@(posedge clk) disable iff (!arst_n)
    !por_ok_s |=> !sys_rst_n_o);

  assert_bor_low_holds_R3: assert property (@(posedge clk) disable iff (!arst_n)
    !bor_ok_s |=> !sys_rst_n_o);

  assert_por_cause_set_R7: assert property (@(posedge clk) disable iff (!arst_n)
    (!por_ok_s && sys_rst_n_o) |=> stat_por_o);

  assert_bor_cause_set_R8: assert property (@(posedge clk) disable iff (!arst_n)
    (por_ok_s && !bor_ok_s && sys_rst_n_o) |=> stat_bor_o);

  assert_por_sticky_R9: assert property (@(posedge clk) disable iff (!arst_n)
    (stat_por_o && !stat_we_i) |=> stat_por_o);

  assert_bor_sticky_R9: assert property (@(posedge clk) disable iff (!arst_n)
    (stat_bor_o && !stat_we_i) |=> stat_bor_o);

  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!arst_n)
    rst_released_o |=> !rst_released_o);

  assert_pulse_on_rise_R10: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(sys_rst_n_o) |-> rst_released_o);

  assert_pulse_when_out_R10: assert property (@(posedge clk) disable iff (!arst_n)
    rst_released_o |-> sys_rst_n_o);
endmodule

bind supply_reset_seq supply_reset_seq_chk i_chk (
  .clk           (clk),
  .arst_n        (arst_n),
  .por_ok_s      (por_ok_s),
  .bor_ok_s      (bor_ok_s),
  .stat_we_i     (stat_we_i),
  .sys_rst_n_o   (sys_rst_n_o),
  .rst_released_o(rst_released_o),
  .stat_por_o    (stat_por_o),
  .stat_bor_o    (stat_bor_o)
);

// File: tb/test_supply_reset_seq.sv
module test_supply_reset_seq;
  localparam int unsigned CLK_HZ = 100_000;
  localparam int P_CYC  = 3;
  localparam int B_CYC  = 10;
  localparam int MS_CYC = 100;

  typedef struct {
    int    cyc;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       arst_n, por_ok, bor_ok, we;
  logic [2:0] sel;
  logic [1:0] wd;
  logic       sys_rst_n_o, rst_released_o, stat_por_o, stat_bor_o;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  supply_reset_seq #(.CLK_HZ(CLK_HZ)) i_supply_reset_seq (
    .clk           (clk),
    .arst_n        (arst_n),
    .por_ok_i      (por_ok),
    .bor_ok_i      (bor_ok),
    .pwrt_sel_i    (sel),
    .stat_we_i     (we),
    .stat_wdata_i  (wd),
    .sys_rst_n_o   (sys_rst_n_o),
    .rst_released_o(rst_released_o),
    .stat_por_o    (stat_por_o),
    .stat_bor_o    (stat_bor_o)
  );

  function automatic int dly(input int k);
    return B_CYC + ((k == 0) ? 0 : (MS_CYC << k));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int c, input string tag);
    exp_t e;
    e.cyc = c;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: each observed release is matched against the scoreboard
  always @(negedge clk) begin
    if (arst_n === 1'b1 && rst_released_o === 1'b1) begin
      if (q.size() == 0) begin
        chk(1'b0, "R10 release with nothing expected", cyc, -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(cyc == e.cyc, e.tag, cyc, e.cyc);
        chk(sys_rst_n_o === 1'b1, "R10 pulse with output high", int'(sys_rst_n_o), 1);
      end
    end
  end

  task automatic drain(input string tag);
    int n = 0;
    while (q.size() != 0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(q.size() == 0, {tag, " release seen"}, q.size(), 0);
    @(negedge clk);
    chk(rst_released_o == 1'b0, "R10 one-cycle pulse", int'(rst_released_o), 0);
    chk(sys_rst_n_o == 1'b1, {tag, " stays released"}, int'(sys_rst_n_o), 1);
  endtask

  task automatic wr(input logic [1:0] v);
    we = 1'b1;
    wd = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    arst_n = 1'b0; por_ok = 1'b0; bor_ok = 1'b0;
    sel = 3'd1; we = 1'b0; wd = 2'b00;
    repeat (3) @(negedge clk);
    chk(sys_rst_n_o == 1'b0, "R1 reset out", int'(sys_rst_n_o), 0);
    chk(rst_released_o == 1'b0, "R1 pulse", int'(rst_released_o), 0);
    chk(stat_por_o == 1'b1, "R1 por cause", int'(stat_por_o), 1);
    chk(stat_bor_o == 1'b0, "R1 bor cause", int'(stat_bor_o), 0);

    arst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sys_rst_n_o == 1'b0, "R2 held while power low", int'(sys_rst_n_o), 0);

    // power up first, brown-out flag later
    por_ok = 1'b1;
    repeat (3 + P_CYC + 6) @(negedge clk);
    chk(sys_rst_n_o == 1'b0, "R3 held while brown-out low", int'(sys_rst_n_o), 0);
    bor_ok = 1'b1;
    push(cyc + 3 + dly(1), "R4 release after B+W code1");
    drain("R4");
    chk(stat_por_o == 1'b1 && stat_bor_o == 1'b0, "R7 cause after power-up",
        {stat_bor_o, stat_por_o}, 1);

    wr(2'b00);
    chk(stat_por_o == 1'b0 && stat_bor_o == 1'b0, "R9 clear by write",
        {stat_bor_o, stat_por_o}, 0);

    // brown-out and drop timing
    bor_ok = 1'b0;
    repeat (2) @(negedge clk);
    chk(sys_rst_n_o == 1'b1, "R3 still high after two edges", int'(sys_rst_n_o), 1);
    @(negedge clk);
    chk(sys_rst_n_o == 1'b0, "R3 low after third edge", int'(sys_rst_n_o), 0);
    chk(stat_bor_o == 1'b1, "R8 brown-out cause", int'(stat_bor_o), 1);
    chk(stat_por_o == 1'b0, "R8 power cause untouched", int'(stat_por_o), 0);
    sel = 3'd0;
    bor_ok = 1'b1;
    push(cyc + 3 + dly(0), "R5 code0 release");
    drain("R5");

    // longest power-up delay
    bor_ok = 1'b0;
    repeat (4) @(negedge clk);
    sel = 3'd7;
    bor_ok = 1'b1;
    push(cyc + 3 + dly(7), "R5 code7 release");
    drain("R5");

    // glitch inside the delay restarts it
    bor_ok = 1'b0;
    repeat (4) @(negedge clk);
    sel = 3'd3;
    bor_ok = 1'b1;
    repeat (8) @(negedge clk);
    bor_ok = 1'b0;
    @(negedge clk);
    bor_ok = 1'b1;
    push(cyc + 3 + dly(3), "R6 restart after glitch");
    drain("R6");

    // brown-out event and clearing write on the same edge
    wr(2'b11);
    bor_ok = 1'b0;
    repeat (2) @(negedge clk);
    wr(2'b00);
    chk(stat_bor_o == 1'b1, "R9 event beats write (bor)", int'(stat_bor_o), 1);
    chk(stat_por_o == 1'b0, "R9 write applied (por)", int'(stat_por_o), 0);
    sel = 3'd2;
    bor_ok = 1'b1;
    push(cyc + 3 + dly(2), "R5 code2 release");
    drain("R5");

    // power loss with simultaneous brown-out
    wr(2'b00);
    por_ok = 1'b0;
    bor_ok = 1'b0;
    repeat (3) @(negedge clk);
    chk(sys_rst_n_o == 1'b0, "R2 power loss asserts", int'(sys_rst_n_o), 0);
    chk(stat_por_o == 1'b1, "R7 power cause", int'(stat_por_o), 1);
    chk(stat_bor_o == 1'b0, "R7 no brown-out cause", int'(stat_bor_o), 0);
    sel = 3'd1;
    por_ok = 1'b1;
    bor_ok = 1'b1;
    push(cyc + 3 + P_CYC + dly(1), "R2 staged power-up release");
    drain("R2");

    // power event and clearing write on the same edge
    wr(2'b10);
    por_ok = 1'b0;
    repeat (2) @(negedge clk);
    wr(2'b00);
    chk(stat_por_o == 1'b1, "R9 event beats write (por)", int'(stat_por_o), 1);
    chk(stat_bor_o == 1'b0, "R9 write applied (bor)", int'(stat_bor_o), 0);
    por_ok = 1'b1;
    push(cyc + 3 + P_CYC + dly(1), "R2 release after power return");
    drain("R2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule